// File: doc/BRIEF.md
# Pointer-Redirected Register File Address Resolver

This block sits between an instruction decoder and a banked data register file. Each instruction supplies a 7-bit in-bank address and two bank-select bits. Every bank has one address with no storage behind it, the pointer window at offset 00h. An access to that offset goes to the location named by the pointer. The 8-bit pointer value and one bank bit taken from the status register form a 9-bit address. The bank bit is the most significant bit. An access to any other offset goes through to the array unchanged.

If the pointer's low seven bits are zero, the pointer names the window itself. A read then returns zero and a write is dropped. Any flag update in the ALU is outside this block. The pointer itself is an ordinary storage location that normal instructions update. Address resolution is purely combinational. A read-modify-write instruction therefore uses the same resolved address for its read and for its write.

Top module: `ind_file_resolver`

## Requirements
- R1: When `dir_addr` is not 00h, `mem_addr` equals `{dir_bank, dir_addr}`. `dir_bank` forms bits 8:7.
- R2: When `dir_addr` is 00h, `mem_addr` equals `{irp, fsr}`. `irp` is bit 8 and `fsr` fills bits 7:0. `dir_bank` is ignored.
- R3: A window access is self-referencing when `dir_addr` is 00h and `fsr[6:0]` is 00h. A self-referencing read gives `rd_data` = 00h, whatever `mem_rdata` holds.
- R4: A self-referencing write keeps `mem_we` low, so no storage changes.
- R5: In every other case, `mem_we` follows `wr_en`, and `mem_wdata` equals `wr_data` at all times.
- R6: When `rd_en` is high and the access is not self-referencing, `rd_data` equals `mem_rdata`. When `rd_en` is low, `rd_data` is 00h.
- R7: When `rd_en` and `wr_en` are both high in the same cycle, the read and the write use one address. The read returns the old contents and the write lands at the same location.
- R8: A change to `fsr` takes effect on the very next access, with no added latency. A loop that writes 00h through the window while stepping `fsr` from 20h, and stops once `fsr[4]` sets, clears 20h to 2Fh of the bank chosen by `irp` and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_addr | input | 7 | In-bank address from the instruction |
| dir_bank | input | 2 | Bank bits for direct accesses |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Data to write |
| fsr | input | 8 | Pointer register value |
| irp | input | 1 | Status bank bit for pointer accesses |
| mem_rdata | input | 8 | Data read from the array at `mem_addr` |
| mem_addr | output | 9 | Resolved array address |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 8 | Array write data |
| rd_data | output | 8 | Read data returned to the datapath |

## Verification
The block holds no state, so any fault in the resolution logic shows at the ports in the same cycle as the stimulus. A wrong address or a missed redirect appears at once on `mem_addr`. In the bench's array model it also appears one edge later, as data read back from the wrong location. A failure to drop a self-referencing write shows as `mem_we` high while `mem_addr[6:0]` is zero. A failure to return zero on a self-referencing read shows as a nonzero `rd_data` when the window location of the array is preloaded with a nonzero pattern.

// File: rtl/ind_file_resolver.sv
module ind_file_resolver #(
  parameter int DATA_W  = 8,
  parameter int PTR_W   = 8,
  parameter int DIR_W   = 7,
  parameter int IND_LOC = 0,
  parameter int ADDR_W  = PTR_W + 1,
  parameter int BANK_W  = ADDR_W - DIR_W
) (
  input  logic [DIR_W-1:0]  dir_addr,
  input  logic [BANK_W-1:0] dir_bank,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  fsr,
  input  logic              irp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [DIR_W-1:0] WIN = DIR_W'(IND_LOC);

  logic              is_ind;
  logic [ADDR_W-1:0] ptr_addr;
  logic              self_ref;

  assign is_ind   = (dir_addr == WIN);
  assign ptr_addr = {irp, fsr};
  assign self_ref = is_ind && (ptr_addr[DIR_W-1:0] == WIN);

  assign mem_addr  = is_ind ? ptr_addr : {dir_bank, dir_addr};
  assign mem_we    = wr_en && !self_ref;
  assign mem_wdata = wr_data;
  assign rd_data   = (rd_en && !self_ref) ? mem_rdata : '0;

  always_comb begin
    if (mem_we)
      p_no_window_write_r4: assert (mem_addr[DIR_W-1:0] != WIN)
        else $error("write reached the window location");
    if (is_ind)
      p_ptr_route_r2: assert (mem_addr[PTR_W-1:0] == fsr && mem_addr[ADDR_W-1] == irp)
        else $error("pointer route broken");
    if (!is_ind)
      p_direct_bank_r1: assert (mem_addr[ADDR_W-1:DIR_W] == dir_bank)
        else $error("direct bank bits lost");
    if (rd_en && mem_addr[DIR_W-1:0] == WIN)
      p_self_read_zero_r3: assert (rd_data == '0)
        else $error("self read not zero");
    if (!rd_en)
      p_idle_read_r6: assert (rd_data == '0)
        else $error("read data without strobe");
  end

endmodule

// File: tb/test_ind_file_resolver.sv
module test_ind_file_resolver;

  logic       clk = 1'b0;
  logic [6:0] dir_addr;
  logic [1:0] dir_bank;
  logic       rd_en, wr_en, irp;
  logic [7:0] wr_data, fsr, mem_rdata;
  logic [8:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata, rd_data;

  logic [7:0] ram [512];
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ind_file_resolver i_ind_file_resolver (
    .dir_addr(dir_addr), .dir_bank(dir_bank), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .fsr(fsr), .irp(irp), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .rd_data(rd_data)
  );

  assign mem_rdata = ram[mem_addr];
  always_ff @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  function automatic logic [8:0] exp_addr(logic [6:0] a, logic [1:0] b, logic [7:0] p, logic i);
    return (a == 7'h00) ? {i, p} : {b, a};
  endfunction

  function automatic logic exp_self(logic [6:0] a, logic [7:0] p);
    return (a == 7'h00) && (p[6:0] == 7'h00);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic drive(logic [6:0] a, logic [1:0] b, logic r, logic w,
                       logic [7:0] d, logic [7:0] p, logic i);
    @(negedge clk);
    dir_addr = a; dir_bank = b; rd_en = r; wr_en = w; wr_data = d; fsr = p; irp = i;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [8:0] ea;
    logic [7:0] old;
    logic       s;
    for (int k = 0; k < 512; k++) ram[k] = 8'(k * 7 + 3);
    dir_addr = '0; dir_bank = '0; rd_en = 0; wr_en = 0; wr_data = '0; fsr = '0; irp = 0;
    #1;
    chk("R6 idle rd_data", rd_data, 8'h00);
    chk("R5 idle mem_we", mem_we, 1'b0);

    // directed: direct access, bank bits in 8:7
    drive(7'h25, 2'b10, 1, 0, 8'h00, 8'hFF, 1);
    chk("R1 direct addr", mem_addr, 9'h125);
    chk("R6 direct read", rd_data, ram[9'h125]);

    // pointer access ignores dir_bank
    drive(7'h00, 2'b11, 1, 0, 8'h00, 8'h3A, 0);
    chk("R2 ptr addr", mem_addr, 9'h03A);
    drive(7'h00, 2'b00, 1, 0, 8'h00, 8'hC1, 1);
    chk("R2 ptr addr irp", mem_addr, 9'h1C1);

    // self reference: nonzero pattern in the window location
    ram[9'h080] = 8'h5A;
    drive(7'h00, 2'b01, 1, 0, 8'h00, 8'h80, 0);
    chk("R3 self read zero", rd_data, 8'h00);
    drive(7'h00, 2'b01, 0, 1, 8'hEE, 8'h80, 0);
    chk("R4 self write blocked", mem_we, 1'b0);
    drive(7'h00, 2'b00, 0, 1, 8'hEE, 8'h00, 1);
    chk("R4 self write blocked irp", mem_we, 1'b0);
    idle();

    // read-modify-write through the pointer
    old = ram[9'h145];
    drive(7'h00, 2'b00, 1, 1, old + 8'h01, 8'h45, 1);
    chk("R7 rmw addr", mem_addr, 9'h145);
    chk("R7 rmw old data", rd_data, old);
    chk("R7 rmw we", mem_we, 1'b1);
    idle(); #1;
    chk("R7 rmw result", ram[9'h145], old + 8'h01);

    // clear loop from 20h until bit 4 of the pointer sets
    for (int k = 0; k < 512; k++) ram[k] = 8'hA5;
    begin
      logic [7:0] p;
      p = 8'h20;
      while (!p[4]) begin
        drive(7'h00, 2'b11, 0, 1, 8'h00, p, 1);
        chk("R8 loop addr", mem_addr, {1'b1, p});
        p = p + 8'h01;
        if (p[4]) break;
      end
      idle(); #1;
      for (int k = 0; k < 512; k++)
        chk("R8 clear range", ram[k], (k >= 9'h120 && k <= 9'h12F) ? 8'h00 : 8'hA5);
    end

    // constrained random mix
    for (int k = 0; k < 512; k++) ram[k] = 8'(k ^ 8'h3C);
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [6:0] a;
      logic [7:0] p;
      logic [1:0] b;
      logic i, r, w;
      logic [7:0] d;
      a = ($urandom % 4 == 0) ? 7'h00 : 7'($urandom);
      p = ($urandom % 5 == 0) ? {1'($urandom), 7'h00} : 8'($urandom);
      b = 2'($urandom); i = 1'($urandom); r = 1'($urandom); w = 1'($urandom);
      d = 8'($urandom);
      drive(a, b, r, w, d, p, i);
      ea = exp_addr(a, b, p, i);
      s  = exp_self(a, p);
      old = ram[ea];
      chk(a == 0 ? "R2 rand addr" : "R1 rand addr", mem_addr, ea);
      chk(s ? "R4 rand we" : "R5 rand we", mem_we, w && !s);
      chk("R5 rand wdata", mem_wdata, d);
      chk(s ? "R3 rand rd" : "R6 rand rd", rd_data, (r && !s) ? old : 8'h00);
      @(posedge clk); #1;
      if (w && !s) chk("R7 rand stored", ram[ea], d);
      else         chk("R4 rand unchanged", ram[ea], old);
    end

    idle();
    finish_run();
  end

endmodule